// File: doc/BRIEF.md
# Fetch Address Sequencer with Exception Vectoring

This block holds the fetch address of a small 32-bit load/store core and decides where it goes next. On every accepted step it either moves to the following word, follows a jump-and-link to a target, follows a jump through a register, enters the interrupt handler at a fixed vector, or returns from the handler to the address that was interrupted. While no step is accepted, all of its state holds.

Interrupt entry is guarded by an enable input and by an internal handler-active bit. Entry copies the current fetch address into a dedicated saved-address register, jumps to the vector, sets the handler-active bit (masking further interrupts) and raises a one-cycle acknowledge. A return-from-exception reloads the fetch address from the saved-address register and clears the handler-active bit. The link value, always the current fetch address plus one instruction, is offered to the register file for jump-and-link.

Top module: `pc_vector_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes RESET_ADDR (default 0x00001000), `epc` becomes 0, `in_handler` becomes 0 and `irq_ack` becomes 0.
- R2: On an accepted step (`step`=1) with no jump, return or taken interrupt, `pc` increases by 4; with `step`=0, `pc`, `epc` and `in_handler` hold.
- R3: A step with `do_jal`=1 loads `pc` with `jump_tgt`; `link_addr` always equals `pc`+4.
- R4: A step with `do_jr`=1 loads `pc` with `reg_val`; when both `do_jal` and `do_jr` are set, `do_jal` wins.
- R5: A step with `irq`=1, `irq_en`=1 and `in_handler`=0 copies the current `pc` into `epc`, loads `pc` with VECTOR_ADDR (default 0x80000180) and sets `in_handler`.
- R6: An interrupt request has no effect when `irq_en`=0 or `in_handler`=1; the step proceeds as if `irq` were 0.
- R7: `irq_ack` is high for exactly the one cycle in which `pc` first shows the vector after a taken interrupt.
- R8: A step with `do_eret`=1 loads `pc` from `epc` and clears `in_handler`, including when `in_handler` is already 0.
- R9: When several apply in one step the order is: taken interrupt, then return, then jump-and-link/register jump, then sequential advance.
- R10: `irq` is looked at only on an accepted step; a request while `step`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Accept one fetch step this cycle |
| do_jal | input | 1 | Decoded jump-and-link |
| do_jr | input | 1 | Decoded jump through register |
| do_eret | input | 1 | Decoded return from exception |
| jump_tgt | input | 32 | Target of jump-and-link |
| reg_val | input | 32 | Register operand for register jump |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_en | input | 1 | Global interrupt enable |
| pc | output | 32 | Current fetch address |
| link_addr | output | 32 | Return address for the link register |
| epc | output | 32 | Saved interrupted address |
| in_handler | output | 1 | Handler-active bit, masks interrupts |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |

## Verification
The hardest situation to reach is an interrupt request arriving while a handler is already active and a return is being issued in the same step, because it needs the handler-active bit set, then an eret that clears it, then a fresh request on the very next step. The stimulus table walks a single continuous program path through entry, a masked request inside the handler, a jump inside the handler and a return that competes with a jump, and then re-enters on a step that also carries an eret, so priority and masking are seen from the same state history. A return with the handler inactive and a reset in the middle of a run close the sequence.

// File: rtl/pc_vector_unit.sv
module pc_vector_unit #(
  parameter int unsigned  AW          = 32,
  parameter logic [31:0]  RESET_ADDR  = 32'h0000_1000,
  parameter logic [31:0]  VECTOR_ADDR = 32'h8000_0180,
  parameter int unsigned  INSN_BYTES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          do_jal,
  input  logic          do_jr,
  input  logic          do_eret,
  input  logic [AW-1:0] jump_tgt,
  input  logic [AW-1:0] reg_val,
  input  logic          irq,
  input  logic          irq_en,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] link_addr,
  output logic [AW-1:0] epc,
  output logic          in_handler,
  output logic          irq_ack
);
  localparam logic [AW-1:0] STRIDE = AW'(INSN_BYTES);
  localparam logic [AW-1:0] RST_PC = RESET_ADDR[AW-1:0];
  localparam logic [AW-1:0] VEC_PC = VECTOR_ADDR[AW-1:0];

  logic [AW-1:0] pc_q, epc_q, pc_d, seq_pc;
  logic          exl_q, ack_q, take;

  assign seq_pc    = pc_q + STRIDE;
  assign take      = step & irq & irq_en & ~exl_q;
  assign link_addr = seq_pc;

  always_comb begin
    if (take)         pc_d = VEC_PC;
    else if (do_eret) pc_d = epc_q;
    else if (do_jal)  pc_d = jump_tgt;
    else if (do_jr)   pc_d = reg_val;
    else              pc_d = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RST_PC;
      epc_q <= '0;
      exl_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= take;
      if (step) begin
        pc_q <= pc_d;
        if (take) begin
          epc_q <= pc_q;
          exl_q <= 1'b1;
        end else if (do_eret) begin
          exl_q <= 1'b0;
        end
      end
    end
  end

  assign pc         = pc_q;
  assign epc        = epc_q;
  assign in_handler = exl_q;
  assign irq_ack    = ack_q;

  // R5
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && irq && irq_en && !in_handler) |=> (pc == VEC_PC && epc == $past(pc) && in_handler && irq_ack));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_handler && !do_eret && !do_jal && !do_jr) |=> (pc == $past(pc) + STRIDE && !irq_ack));

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R8
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && do_eret && !(irq && irq_en && !in_handler)) |=> (pc == $past(epc) && !in_handler));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && $stable(epc) && $stable(in_handler)));

  // R3
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_addr == pc + STRIDE);
endmodule

// File: tb/pc_vector_unit_tb_top.sv
module pc_vector_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] VEC_PC = 32'h8000_0180;

  typedef struct packed {
    logic        step, jal, jr, eret, irq, ien;
    logic [31:0] tgt, regv, exp_pc, exp_epc;
    logic        exp_exl, exp_ack;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TABLE [NV] = '{
    // R2 sequential
    '{1,0,0,0,0,0, 32'h0, 32'h0, 32'h0000_1004, 32'h0, 0, 0, 8'd2},
    // R2 hold
    '{0,0,0,0,0,0, 32'h0, 32'h0, 32'h0000_1004, 32'h0, 0, 0, 8'd2},
    // R3 jal
    '{1,1,0,0,0,0, 32'h0000_2000, 32'h0, 32'h0000_2000, 32'h0, 0, 0, 8'd3},
    // R4 jr
    '{1,0,1,0,0,0, 32'h0, 32'h0000_3000, 32'h0000_3000, 32'h0, 0, 0, 8'd4},
    // R4 jal beats jr
    '{1,1,1,0,0,0, 32'h0000_2400, 32'h0000_3300, 32'h0000_2400, 32'h0, 0, 0, 8'd4},
    // R10 irq without step
    '{0,0,0,0,1,1, 32'h0, 32'h0, 32'h0000_2400, 32'h0, 0, 0, 8'd10},
    // R6 irq with enable low
    '{1,0,0,0,1,0, 32'h0, 32'h0, 32'h0000_2404, 32'h0, 0, 0, 8'd6},
    // R5 / R7 entry
    '{1,0,0,0,1,1, 32'h0, 32'h0, VEC_PC, 32'h0000_2404, 1, 1, 8'd5},
    // R6 / R7 masked inside handler, ack drops
    '{1,0,0,0,1,1, 32'h0, 32'h0, 32'h8000_0184, 32'h0000_2404, 1, 0, 8'd7},
    // R3 jal inside handler
    '{1,1,0,0,0,0, 32'h0000_5000, 32'h0, 32'h0000_5000, 32'h0000_2404, 1, 0, 8'd3},
    // R9 eret beats jal
    '{1,1,0,1,0,0, 32'h0000_6000, 32'h0, 32'h0000_2404, 32'h0000_2404, 0, 0, 8'd9},
    // R9 irq beats eret
    '{1,0,0,1,1,1, 32'h0, 32'h0, VEC_PC, 32'h0000_2404, 1, 1, 8'd9},
    // R8 return
    '{1,0,0,1,0,0, 32'h0, 32'h0, 32'h0000_2404, 32'h0000_2404, 0, 0, 8'd8},
    // R8 eret with handler inactive
    '{1,0,0,1,0,0, 32'h0, 32'h0, 32'h0000_2404, 32'h0000_2404, 0, 0, 8'd8},
    // R2 advance again
    '{1,0,0,0,0,0, 32'h0, 32'h0, 32'h0000_2408, 32'h0000_2404, 0, 0, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 0, do_jal = 0, do_jr = 0, do_eret = 0, irq = 0, irq_en = 0;
  logic [31:0] jump_tgt = '0, reg_val = '0;
  logic [31:0] pc, link_addr, epc;
  logic in_handler, irq_ack;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .do_jal(do_jal), .do_jr(do_jr),
    .do_eret(do_eret), .jump_tgt(jump_tgt), .reg_val(reg_val), .irq(irq),
    .irq_en(irq_en), .pc(pc), .link_addr(link_addr), .epc(epc),
    .in_handler(in_handler), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    step = v.step; do_jal = v.jal; do_jr = v.jr; do_eret = v.eret;
    irq = v.irq; irq_en = v.ien; jump_tgt = v.tgt; reg_val = v.regv;
    @(posedge clk);
    #1;
  endtask

  task automatic check_reset(input string tag);
    check(tag, "pc", pc, RST_PC);
    check(tag, "epc", epc, 32'h0);
    check(tag, "in_handler", {31'h0, in_handler}, 32'h0);
    check(tag, "irq_ack", {31'h0, irq_ack}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset("R1");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(TABLE[i]);
      tag = $sformatf("R%0d row%0d", TABLE[i].req, i);
      check(tag, "pc", pc, TABLE[i].exp_pc);
      check(tag, "epc", epc, TABLE[i].exp_epc);
      check(tag, "in_handler", {31'h0, in_handler}, {31'h0, TABLE[i].exp_exl});
      check(tag, "irq_ack", {31'h0, irq_ack}, {31'h0, TABLE[i].exp_ack});
      check("R3 link", "link_addr", link_addr, TABLE[i].exp_pc + 32'd4);
    end

    // R7: entry followed by idle cycles, ack lasts one cycle only
    drive('{1,0,0,0,1,1, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 8'd7});
    check("R7 entry", "irq_ack", {31'h0, irq_ack}, 32'h1);
    check("R5 save", "epc", epc, 32'h0000_2408);
    drive('{0,0,0,0,1,1, 32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 8'd7});
    check("R7 drop", "irq_ack", {31'h0, irq_ack}, 32'h0);
    check("R10 idle", "pc", pc, VEC_PC);

    // R1: reset in the middle of a handler
    @(negedge clk);
    rst_n = 1'b0; step = 1'b1; do_jal = 1'b1; jump_tgt = 32'h0000_7000;
    @(posedge clk);
    #1;
    check_reset("R1 midrun");
    @(negedge clk);
    rst_n = 1'b1; step = 0; do_jal = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule